// File: doc/BRIEF.md
# Address Segment and TLB Fault Unit

This block sits between a processor's address generation and its memory system. For each access it decides which of four fixed regions of the 32-bit virtual space the address falls in. Two kernel regions are windows straight onto physical memory: one is cached and the other is not. The low user region and the top kernel region are translated through an external TLB. The block combines the TLB's lookup result with the access direction and the current privilege level. From these it produces either a physical address with its cache attribute or a memory-management exception.

When an exception is taken, the block does three things on the next clock edge. It records the restart PC and the faulting address, and stores the exception code. For TLB-class faults it also preloads the page-number field of the translation-staging register. In every case it pushes the privilege/interrupt stack into kernel mode with interrupts masked. It also steers the next PC. A translation miss in the user region goes to a dedicated fast-refill entry point. Every other fault goes to the general entry point. A return-from-exception strobe pops the privilege stack. A status write port lets kernel code set the stack directly.

Top module: `mmu_fault_unit`

## Requirements
- R1: A kernel access with vaddr[31:29] = 3'b100 yields paddr = vaddr - 0x80000000 with cacheable = 1. A kernel access with vaddr[31:29] = 3'b101 yields paddr = vaddr - 0xA0000000 with cacheable = 0. Neither raises an exception or depends on the TLB inputs.
- R2: An access to a mapped region passes the checks below. Mapped means vaddr[31] = 0, or vaddr[31:30] = 2'b11 in kernel mode. The checks are: TLB hit with the valid bit set, and for stores the dirty bit set. Such an access yields paddr = {tlb_pfn, vaddr[11:0]} with cacheable = !tlb_nocache and no exception.
- R3: A TLB miss on an address with vaddr[31] = 0 raises an exception with next_pc = 0x80000000. The recorded code is 2 for a load or 3 for a store.
- R4: A TLB miss on an address with vaddr[31:30] = 2'b11 raises an exception with next_pc = 0x80000080. The code is 2 for a load or 3 for a store.
- R5: A TLB hit on an entry whose valid bit is clear raises an exception with next_pc = 0x80000080. The code is 2 for a load or 3 for a store.
- R6: A store that hits a valid entry whose dirty bit is clear raises an exception with code 1 and next_pc = 0x80000080. A load to the same entry translates normally.
- R7: In user mode, status[1] = 0, any access with vaddr[31] = 1 raises an address error regardless of the TLB inputs. The code is 4 for a load or 5 for a store, with next_pc = 0x80000080.
- R8: On the clock edge that takes an exception, epc is loaded with pc and badvaddr with vaddr.
- R9: A TLB-class exception loads entryhi_vpn with vaddr[31:12]. The TLB-class codes are 1, 2 and 3. An address error leaves entryhi_vpn unchanged.
- R10: status holds three {kernel, int_enable} pairs: current in [1:0], previous in [3:2], old in [5:4]. It resets to 6'b000010. An exception shifts the stack up and sets the current pair to 2'b10. rfe shifts it down, with the old pair kept. status_wr loads status_wdata. The priority is exception over rfe over write.
- R11: With req_valid low, exc_strobe stays 0 and epc, badvaddr, exc_code, entryhi_vpn and status do not change, whatever the other access inputs are.
- R12: When no exception is raised, next_pc = pc + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | An access is presented this cycle |
| vaddr | input | 32 | Virtual address of the access |
| is_store | input | 1 | 1 = store, 0 = load |
| pc | input | 32 | PC of the accessing instruction |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_pfn | input | 20 | Frame number from the matching entry |
| tlb_valid | input | 1 | Valid bit of the matching entry |
| tlb_dirty | input | 1 | Write-enable (dirty) bit of the matching entry |
| tlb_nocache | input | 1 | Uncached bit of the matching entry |
| rfe | input | 1 | Return-from-exception strobe |
| status_wr | input | 1 | Load status from status_wdata |
| status_wdata | input | 6 | Value for a status write |
| paddr | output | 32 | Physical address (0 on a fault) |
| cacheable | output | 1 | Access may be cached |
| xlat_ok | output | 1 | Access translated without fault |
| exc_strobe | output | 1 | Exception raised this cycle |
| next_pc | output | 32 | Handler vector on exception, else pc + 4 |
| epc | output | 32 | Saved restart PC |
| badvaddr | output | 32 | Saved faulting address |
| exc_code | output | 5 | Code of the last exception |
| entryhi_vpn | output | 20 | Preloaded virtual page number |
| status | output | 6 | Privilege/interrupt stack |

## Verification
The assertions check the per-cycle relations. A user-region miss always selects the refill vector. A user-mode access to the upper half always faults through the general vector. The uncached kernel window never caches. Every exception captures pc and vaddr and pushes the stack. An idle cycle changes no control state. The bench sweeps every region in both privilege levels across both directions and four TLB result types, with both cache attributes. Only that sweep can show that the exact physical addresses and codes are right. It also shows that entryhi_vpn is preserved across address errors. Directed sequences show the stack popping on rfe and the priority between simultaneous exception, rfe and write.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int unsigned VA_W = 32;

    localparam logic [VA_W-1:0] KSEG0_BASE = 32'h8000_0000;
    localparam logic [VA_W-1:0] KSEG1_BASE = 32'hA000_0000;

    typedef enum logic [1:0] {
        SEG_USER = 2'd0,
        SEG_K0   = 2'd1,
        SEG_K1   = 2'd2,
        SEG_K2   = 2'd3
    } seg_e;

    typedef enum logic [4:0] {
        EXC_NONE = 5'd0,
        EXC_MOD  = 5'd1,
        EXC_TLBL = 5'd2,
        EXC_TLBS = 5'd3,
        EXC_ADEL = 5'd4,
        EXC_ADES = 5'd5
    } exc_code_e;

    typedef struct packed {
        logic            fault;
        exc_code_e       code;
        logic            refill;
        logic            tlb_class;
        logic [VA_W-1:0] paddr;
        logic            cacheable;
    } xlat_t;

    // Region from the top three address bits.
    function automatic seg_e seg_of(input logic [VA_W-1:0] va);
        seg_e s;
        if (!va[31])            s = SEG_USER;
        else if (va[30])        s = SEG_K2;
        else if (va[29])        s = SEG_K1;
        else                    s = SEG_K0;
        return s;
    endfunction

    function automatic exc_code_e dir_code(input logic st,
                                           input exc_code_e ld_code,
                                           input exc_code_e st_code);
        return st ? st_code : ld_code;
    endfunction

endpackage

// File: rtl/seg_decode.sv
module seg_decode
    import mmu_pkg::*;
(
    input  logic [VA_W-1:0] vaddr,
    output seg_e            seg,
    output logic            mapped,
    output logic            upper_half,
    output logic [VA_W-1:0] direct_pa,
    output logic            direct_cache
);
    always_comb begin
        seg          = seg_of(vaddr);
        upper_half   = vaddr[VA_W-1];
        mapped       = (seg == SEG_USER) || (seg == SEG_K2);
        direct_pa    = '0;
        direct_cache = 1'b0;
        unique case (seg)
            SEG_K0: begin
                direct_pa    = vaddr - KSEG0_BASE;
                direct_cache = 1'b1;
            end
            SEG_K1: begin
                direct_pa    = vaddr - KSEG1_BASE;
                direct_cache = 1'b0;
            end
            default: begin
                direct_pa    = '0;
                direct_cache = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fault_classify.sv
module fault_classify
    import mmu_pkg::*;
#(
    parameter int unsigned PAGE_OFF_W = 12,
    localparam int unsigned PFN_W     = VA_W - PAGE_OFF_W
) (
    input  logic             req_valid,
    input  logic             is_store,
    input  logic             user_mode,
    input  logic [VA_W-1:0]  vaddr,
    input  seg_e             seg,
    input  logic             mapped,
    input  logic             upper_half,
    input  logic [VA_W-1:0]  direct_pa,
    input  logic             direct_cache,
    input  logic             tlb_hit,
    input  logic [PFN_W-1:0] tlb_pfn,
    input  logic             tlb_valid,
    input  logic             tlb_dirty,
    input  logic             tlb_nocache,
    output xlat_t            res
);
    always_comb begin
        res.fault     = 1'b0;
        res.code      = EXC_NONE;
        res.refill    = 1'b0;
        res.tlb_class = 1'b0;
        res.paddr     = '0;
        res.cacheable = 1'b0;

        if (user_mode && upper_half) begin
            // privilege violation takes precedence over any translation
            res.fault = 1'b1;
            res.code  = dir_code(is_store, EXC_ADEL, EXC_ADES);
        end else if (!mapped) begin
            res.paddr     = direct_pa;
            res.cacheable = direct_cache;
        end else if (!tlb_hit) begin
            res.fault     = 1'b1;
            res.tlb_class = 1'b1;
            res.code      = dir_code(is_store, EXC_TLBL, EXC_TLBS);
            res.refill    = (seg == SEG_USER);
        end else if (!tlb_valid) begin
            res.fault     = 1'b1;
            res.tlb_class = 1'b1;
            res.code      = dir_code(is_store, EXC_TLBL, EXC_TLBS);
        end else if (is_store && !tlb_dirty) begin
            res.fault     = 1'b1;
            res.tlb_class = 1'b1;
            res.code      = EXC_MOD;
        end else begin
            res.paddr     = {tlb_pfn, vaddr[PAGE_OFF_W-1:0]};
            res.cacheable = !tlb_nocache;
        end

        if (!req_valid) begin
            res.fault     = 1'b0;
            res.code      = EXC_NONE;
            res.refill    = 1'b0;
            res.tlb_class = 1'b0;
            res.paddr     = '0;
            res.cacheable = 1'b0;
        end
    end
endmodule

// File: rtl/cp0_state.sv
module cp0_state
    import mmu_pkg::*;
#(
    parameter int unsigned PAGE_OFF_W = 12,
    parameter int unsigned MODE_DEPTH = 3,
    localparam int unsigned PFN_W     = VA_W - PAGE_OFF_W,
    localparam int unsigned ST_W      = 2 * MODE_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take_exc,
    input  logic             tlb_class,
    input  exc_code_e        code,
    input  logic [VA_W-1:0]  pc,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             rfe,
    input  logic             status_wr,
    input  logic [ST_W-1:0]  status_wdata,
    output logic [VA_W-1:0]  epc,
    output logic [VA_W-1:0]  badvaddr,
    output logic [4:0]       exc_code,
    output logic [PFN_W-1:0] entryhi_vpn,
    output logic [ST_W-1:0]  status
);
    localparam logic [1:0]      KERNEL_MASKED = 2'b10;
    localparam logic [ST_W-1:0] STATUS_RST    = {{(ST_W-2){1'b0}}, KERNEL_MASKED};

    logic [ST_W-1:0] pushed;
    logic [ST_W-1:0] popped;

    for (genvar k = 0; k < MODE_DEPTH; k++) begin : g_pair
        if (k == 0) begin : g_bottom
            assign pushed[1:0] = KERNEL_MASKED;
        end else begin : g_shift_up
            assign pushed[2*k+1:2*k] = status[2*k-1:2*k-2];
        end
        if (k == MODE_DEPTH - 1) begin : g_top
            assign popped[2*k+1:2*k] = status[2*k+1:2*k];
        end else begin : g_shift_down
            assign popped[2*k+1:2*k] = status[2*k+3:2*k+2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            epc         <= '0;
            badvaddr    <= '0;
            exc_code    <= '0;
            entryhi_vpn <= '0;
            status      <= STATUS_RST;
        end else if (take_exc) begin
            epc      <= pc;
            badvaddr <= vaddr;
            exc_code <= code;
            status   <= pushed;
            if (tlb_class) begin
                entryhi_vpn <= vaddr[VA_W-1:PAGE_OFF_W];
            end
        end else if (rfe) begin
            status <= popped;
        end else if (status_wr) begin
            status <= status_wdata;
        end
    end
endmodule

// File: rtl/mmu_fault_unit.sv
module mmu_fault_unit
    import mmu_pkg::*;
#(
    parameter int unsigned     PAGE_OFF_W  = 12,
    parameter int unsigned     MODE_DEPTH  = 3,
    parameter logic [31:0]     REFILL_VEC  = 32'h8000_0000,
    parameter logic [31:0]     GENERAL_VEC = 32'h8000_0080,
    localparam int unsigned    PFN_W       = VA_W - PAGE_OFF_W,
    localparam int unsigned    ST_W        = 2 * MODE_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             is_store,
    input  logic [VA_W-1:0]  pc,
    input  logic             tlb_hit,
    input  logic [PFN_W-1:0] tlb_pfn,
    input  logic             tlb_valid,
    input  logic             tlb_dirty,
    input  logic             tlb_nocache,
    input  logic             rfe,
    input  logic             status_wr,
    input  logic [ST_W-1:0]  status_wdata,
    output logic [VA_W-1:0]  paddr,
    output logic             cacheable,
    output logic             xlat_ok,
    output logic             exc_strobe,
    output logic [VA_W-1:0]  next_pc,
    output logic [VA_W-1:0]  epc,
    output logic [VA_W-1:0]  badvaddr,
    output logic [4:0]       exc_code,
    output logic [PFN_W-1:0] entryhi_vpn,
    output logic [ST_W-1:0]  status
);
    seg_e            seg;
    logic            mapped;
    logic            upper_half;
    logic [VA_W-1:0] direct_pa;
    logic            direct_cache;
    xlat_t           res;
    logic            user_mode;

    assign user_mode = !status[1];

    seg_decode u_seg (
        .vaddr       (vaddr),
        .seg         (seg),
        .mapped      (mapped),
        .upper_half  (upper_half),
        .direct_pa   (direct_pa),
        .direct_cache(direct_cache)
    );

    fault_classify #(.PAGE_OFF_W(PAGE_OFF_W)) u_cls (
        .req_valid   (req_valid),
        .is_store    (is_store),
        .user_mode   (user_mode),
        .vaddr       (vaddr),
        .seg         (seg),
        .mapped      (mapped),
        .upper_half  (upper_half),
        .direct_pa   (direct_pa),
        .direct_cache(direct_cache),
        .tlb_hit     (tlb_hit),
        .tlb_pfn     (tlb_pfn),
        .tlb_valid   (tlb_valid),
        .tlb_dirty   (tlb_dirty),
        .tlb_nocache (tlb_nocache),
        .res         (res)
    );

    cp0_state #(.PAGE_OFF_W(PAGE_OFF_W), .MODE_DEPTH(MODE_DEPTH)) u_cp0 (
        .clk         (clk),
        .rst         (rst),
        .take_exc    (res.fault),
        .tlb_class   (res.tlb_class),
        .code        (res.code),
        .pc          (pc),
        .vaddr       (vaddr),
        .rfe         (rfe),
        .status_wr   (status_wr),
        .status_wdata(status_wdata),
        .epc         (epc),
        .badvaddr    (badvaddr),
        .exc_code    (exc_code),
        .entryhi_vpn (entryhi_vpn),
        .status      (status)
    );

    always_comb begin
        paddr      = res.paddr;
        cacheable  = res.cacheable;
        exc_strobe = res.fault;
        xlat_ok    = req_valid && !res.fault;
        if (res.fault) begin
            next_pc = res.refill ? REFILL_VEC : GENERAL_VEC;
        end else begin
            next_pc = pc + 32'd4;
        end
    end
endmodule

// File: rtl/mmu_fault_checker.sv
module mmu_fault_checker #(
    parameter int unsigned MODE_DEPTH  = 3,
    parameter logic [31:0] REFILL_VEC  = 32'h8000_0000,
    parameter logic [31:0] GENERAL_VEC = 32'h8000_0080,
    localparam int unsigned ST_W       = 2 * MODE_DEPTH
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic [31:0]     vaddr,
    input logic [31:0]     pc,
    input logic            tlb_hit,
    input logic            rfe,
    input logic            status_wr,
    input logic            exc_strobe,
    input logic            cacheable,
    input logic [31:0]     next_pc,
    input logic [31:0]     epc,
    input logic [31:0]     badvaddr,
    input logic [ST_W-1:0] status
);
    p_refill_vec_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !vaddr[31] && !tlb_hit) |-> (exc_strobe && next_pc == REFILL_VEC));

    p_user_upper_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !status[1] && vaddr[31]) |-> (exc_strobe && next_pc == GENERAL_VEC));

    p_uncached_win_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && status[1] && vaddr[31:29] == 3'b101) |-> (!cacheable && !exc_strobe));

    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        exc_strobe |=> (epc == $past(pc) && badvaddr == $past(vaddr)));

    p_push_r10: assert property (@(posedge clk) disable iff (rst)
        exc_strobe |=> (status[1:0] == 2'b10 && status[3:2] == $past(status[1:0])));

    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!req_valid && !rfe && !status_wr) |=> ($stable(status) && $stable(epc) && $stable(badvaddr)));

    p_no_exc_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !exc_strobe);
endmodule

bind mmu_fault_unit mmu_fault_checker #(
    .MODE_DEPTH (MODE_DEPTH),
    .REFILL_VEC (REFILL_VEC),
    .GENERAL_VEC(GENERAL_VEC)
) u_mmu_fault_checker (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .vaddr     (vaddr),
    .pc        (pc),
    .tlb_hit   (tlb_hit),
    .rfe       (rfe),
    .status_wr (status_wr),
    .exc_strobe(exc_strobe),
    .cacheable (cacheable),
    .next_pc   (next_pc),
    .epc       (epc),
    .badvaddr  (badvaddr),
    .status    (status)
);

// File: tb/test_mmu_fault_unit.sv
module test_mmu_fault_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] vaddr;
    logic        is_store;
    logic [31:0] pc;
    logic        tlb_hit;
    logic [19:0] tlb_pfn;
    logic        tlb_valid;
    logic        tlb_dirty;
    logic        tlb_nocache;
    logic        rfe;
    logic        status_wr;
    logic [5:0]  status_wdata;
    logic [31:0] paddr;
    logic        cacheable;
    logic        xlat_ok;
    logic        exc_strobe;
    logic [31:0] next_pc;
    logic [31:0] epc;
    logic [31:0] badvaddr;
    logic [4:0]  exc_code;
    logic [19:0] entryhi_vpn;
    logic [5:0]  status;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    mmu_fault_unit i_mmu_fault_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .vaddr(vaddr),
        .is_store(is_store), .pc(pc), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
        .tlb_valid(tlb_valid), .tlb_dirty(tlb_dirty), .tlb_nocache(tlb_nocache),
        .rfe(rfe), .status_wr(status_wr), .status_wdata(status_wdata),
        .paddr(paddr), .cacheable(cacheable), .xlat_ok(xlat_ok),
        .exc_strobe(exc_strobe), .next_pc(next_pc), .epc(epc),
        .badvaddr(badvaddr), .exc_code(exc_code), .entryhi_vpn(entryhi_vpn),
        .status(status)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    // bench model of registered state
    logic [31:0] m_epc, m_badv;
    logic [4:0]  m_code;
    logic [19:0] m_hi;
    logic [5:0]  m_status;

    task automatic write_status(input logic [5:0] w);
        @(negedge clk);
        status_wr    = 1'b1;
        status_wdata = w;
        @(negedge clk);
        status_wr = 1'b0;
        m_status  = w;
        check("R10 status write", {26'd0, status}, {26'd0, w});
    endtask

    initial begin
        rst = 1'b1; req_valid = 0; vaddr = 0; is_store = 0; pc = 0;
        tlb_hit = 0; tlb_pfn = 0; tlb_valid = 0; tlb_dirty = 0; tlb_nocache = 0;
        rfe = 0; status_wr = 0; status_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R10 status reset value)
        check("R10 reset status", {26'd0, status}, 32'h2);
        check("R8 reset epc", epc, 32'h0);
        check("R8 reset badvaddr", badvaddr, 32'h0);
        check("R9 reset entryhi", {12'd0, entryhi_vpn}, 32'h0);
        check("R11 reset no strobe", {31'd0, exc_strobe}, 32'h0);
        m_epc = 0; m_badv = 0; m_code = 0; m_hi = 0; m_status = 6'b000010;

        // sweep: privilege x region x direction x TLB result x cache attr
        for (int idx = 0; idx < 128; idx++) begin
            automatic int mode = idx / 64;
            automatic int seg  = (idx / 16) % 4;
            automatic int st   = (idx / 8) % 2;
            automatic int tc   = (idx / 2) % 4;
            automatic int nc   = idx % 2;
            automatic logic [31:0] base, mask, va, epa, evec, ipc;
            automatic logic [19:0] pfn;
            automatic logic [5:0]  w;
            automatic logic        eexc, ecache, etlb;
            automatic logic [4:0]  ecode;
            automatic string       rq;

            w = (mode == 1) ? 6'b100101 : 6'b011010;
            write_status(w);

            case (seg)
                0: begin base = 32'h0000_0000; mask = 32'h7FFF_FFFF; end
                1: begin base = 32'h8000_0000; mask = 32'h1FFF_FFFF; end
                2: begin base = 32'hA000_0000; mask = 32'h1FFF_FFFF; end
                default: begin base = 32'hC000_0000; mask = 32'h3FFF_FFFF; end
            endcase
            va  = base + ((idx * 32'h0003_7A5C + 32'h0000_0ABC) & mask);
            pfn = 20'(idx * 32'h731) ^ 20'h5A5A5;
            ipc = 32'h0040_0000 + idx * 4;

            eexc = 0; ecode = 0; evec = 32'h8000_0080; etlb = 0; epa = 0; ecache = 0;
            if (mode == 1 && va[31]) begin
                eexc = 1; ecode = st ? 5'd5 : 5'd4; rq = "R7";
            end else if (seg == 1) begin
                epa = va - 32'h8000_0000; ecache = 1; rq = "R1";
            end else if (seg == 2) begin
                epa = va - 32'hA000_0000; ecache = 0; rq = "R1";
            end else if (tc == 0) begin
                eexc = 1; etlb = 1; ecode = st ? 5'd3 : 5'd2;
                if (seg == 0) begin evec = 32'h8000_0000; rq = "R3"; end
                else rq = "R4";
            end else if (tc == 1) begin
                eexc = 1; etlb = 1; ecode = st ? 5'd3 : 5'd2; rq = "R5";
            end else if (tc == 2 && st == 1) begin
                eexc = 1; etlb = 1; ecode = 5'd1; rq = "R6";
            end else begin
                epa = {pfn, va[11:0]}; ecache = (nc == 0); rq = (tc == 2) ? "R6" : "R2";
            end

            @(negedge clk);
            req_valid = 1; vaddr = va; is_store = st[0]; pc = ipc;
            tlb_hit = (tc != 0); tlb_pfn = pfn; tlb_valid = (tc >= 2);
            tlb_dirty = (tc == 3); tlb_nocache = nc[0];
            #1;
            check({rq, " exc_strobe"}, {31'd0, exc_strobe}, {31'd0, eexc});
            if (eexc) begin
                check({rq, " vector"}, next_pc, evec);
            end else begin
                check("R12 next_pc", next_pc, ipc + 4);
                check({rq, " paddr"}, paddr, epa);
                check({rq, " cacheable"}, {31'd0, cacheable}, {31'd0, ecache});
            end
            @(negedge clk);
            req_valid = 0;
            if (eexc) begin
                m_epc = ipc; m_badv = va; m_code = ecode;
                m_status = {w[3:0], 2'b10};
                if (etlb) m_hi = va[31:12];
            end
            check("R8 epc", epc, m_epc);
            check("R8 badvaddr", badvaddr, m_badv);
            check({rq, " code"}, {27'd0, exc_code}, {27'd0, m_code});
            check("R9 entryhi", {12'd0, entryhi_vpn}, {12'd0, m_hi});
            check("R10 status after access", {26'd0, status}, {26'd0, m_status});
        end

        // R11: faulting inputs with req_valid low change nothing
        @(negedge clk);
        req_valid = 0; vaddr = 32'hFFFF_F000; is_store = 1; pc = 32'h1234_5678;
        tlb_hit = 0;
        #1;
        check("R11 idle no strobe", {31'd0, exc_strobe}, 32'h0);
        check("R11 idle next_pc", next_pc, 32'h1234_567C);
        @(negedge clk);
        check("R11 idle epc", epc, m_epc);
        check("R11 idle code", {27'd0, exc_code}, {27'd0, m_code});
        check("R11 idle status", {26'd0, status}, {26'd0, m_status});

        // R10: rfe pops, old pair kept
        write_status(6'b100110);
        @(negedge clk); rfe = 1;
        @(negedge clk); rfe = 0;
        check("R10 rfe pop", {26'd0, status}, {26'd0, 6'b101001});
        @(negedge clk); rfe = 1;
        @(negedge clk); rfe = 0;
        check("R10 rfe pop twice", {26'd0, status}, {26'd0, 6'b101010});

        // R10: exception beats rfe and write in the same cycle
        write_status(6'b000001);
        @(negedge clk);
        req_valid = 1; vaddr = 32'h8000_1000; is_store = 0; pc = 32'h0000_0100;
        rfe = 1; status_wr = 1; status_wdata = 6'b111111;
        @(negedge clk);
        req_valid = 0; rfe = 0; status_wr = 0;
        check("R10 exc over rfe/write", {26'd0, status}, {26'd0, 6'b000110});
        check("R7 code address error load", {27'd0, exc_code}, 32'd4);
        check("R9 entryhi kept on address error", {12'd0, entryhi_vpn}, {12'd0, m_hi});

        // R10: rfe beats write
        @(negedge clk); rfe = 1; status_wr = 1; status_wdata = 6'b111111;
        @(negedge clk); rfe = 0; status_wr = 0;
        check("R10 rfe over write", {26'd0, status}, {26'd0, 6'b000001});

        finish_run();
    end
endmodule